// File: doc/BRIEF.md
# ECC Single-Bit Error Locator

This block takes a 64-bit data word and its check code as they were captured at the moment a memory error was detected. It works out which single line failed and what the word should have been. It recomputes eight check bits from the data with a fixed parity matrix. XORing these with the captured code gives the syndrome. The syndrome is then compared against the column code of every data line, and if no data line fits, the lowest set syndrome bit names a failed check line. A syndrome that fits no data line and has more than one bit set is flagged as uncorrectable.

An error handler pulses `start_i` with the captured word, the captured code, the single-bit-error flag and the bus-width indication. One clock later `valid_o` pulses and the registered results are presented. The results hold until the next start. Decoding is only carried out for single-bit errors on a 64-bit bus. In every other case the block still reports the masked captured code and passes the captured values through as the expected values.

Top module: `ecc_sbe_locator`

## Requirements
- R1: Check bit i (0..7) is the XOR of the data bits selected by parity mask i, where data bit b uses bit b of the 64-bit mask {upper half, lower half}. The masks are: 0: F00FE11E_C33C0FF7, 1: 00FF00FF_00FFF0FF, 2: 0F0F0F0F_0F0FFF00, 3: 11113333_7777000F, 4: 22224444_8888222F, 5: 44448888_FFFF4441, 6: 8888FFFF_11118882, 7: FFFF1111_22221114. The syndrome is this recomputed code XOR the low 8 bits of the masked captured code.
- R2: `syndrome_o` is the captured code masked by bus width. With `bus64_i`=1 only bits 7:0 are kept and the rest read zero. With `bus64_i`=0 all CAP_W (16) bits are kept.
- R3: Data line b has the column code whose bit i is bit b of mask i. Data lines are compared in ascending order 0..63, and the first one whose column equals a nonzero syndrome is reported on `data_bad_idx_o` with `data_bad_vld_o`=1. No check line is then reported.
- R4: If a nonzero syndrome matches no data column, the index of its lowest set bit is reported on `chk_bad_idx_o` with `chk_bad_vld_o`=1.
- R5: `uncorr_o` is 1 exactly when a nonzero syndrome matches no data column and has two or more bits set.
- R6: A zero syndrome reports no failed line: both valid flags and `uncorr_o` are 0, and the expected values equal the captured ones.
- R7: Decoding runs only when `sbe_i`=1 and `bus64_i`=1. Otherwise all three flags are 0 and the expected values equal the captured data and masked code.
- R8: `exp_data_o` is the captured data with the reported data bit inverted. `exp_chk_o` is the masked captured code with the reported check bit inverted.
- R9: `valid_o` is high for exactly the one cycle after a cycle with `start_i` high. Results hold their values until the next start.
- R10: After reset, `valid_o` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request; inputs are sampled on this edge |
| data_i | input | 64 | Captured data word |
| cap_code_i | input | CAP_W (16) | Captured check code register |
| sbe_i | input | 1 | Single-bit-error flag |
| bus64_i | input | 1 | 1 = 64-bit bus, 0 = 32-bit bus |
| valid_o | output | 1 | Result valid pulse, one cycle after start |
| data_bad_vld_o | output | 1 | A data line was located |
| data_bad_idx_o | output | 6 | Index of the failed data line |
| chk_bad_vld_o | output | 1 | A check line was located |
| chk_bad_idx_o | output | 3 | Index of the failed check line |
| uncorr_o | output | 1 | No single location explains the syndrome |
| exp_data_o | output | 64 | Corrected data word |
| exp_chk_o | output | CAP_W (16) | Corrected masked check code |
| syndrome_o | output | CAP_W (16) | Captured code masked by bus width |

## Verification
The bench builds the block with its default CAP_W of 16. This makes the 32-bit masking case observable, because the upper byte of the captured code must survive there and vanish in 64-bit mode. Random words are encoded with a bench model of the matrix and then given zero, one or two flipped lines, with the flag and bus width drawn at random. This reaches data matches, check-bit fallbacks and uncorrectable syndromes across the whole matrix. Directed words cover the first and last data line, the top check line, a clean word and both gating conditions.

// File: rtl/ecc_loc_pkg.sv
package ecc_loc_pkg;

    localparam int LOC_DATA_W = 64;
    localparam int LOC_CHK_W  = 8;
    localparam int LOC_DIDX_W = $clog2(LOC_DATA_W);
    localparam int LOC_CIDX_W = $clog2(LOC_CHK_W);

    // Parity matrix rows; bit b of row i selects data bit b for check bit i.
    localparam logic [LOC_DATA_W-1:0] LOC_MASK [LOC_CHK_W] = '{
        64'hF00FE11E_C33C0FF7,
        64'h00FF00FF_00FFF0FF,
        64'h0F0F0F0F_0F0FFF00,
        64'h11113333_7777000F,
        64'h22224444_8888222F,
        64'h44448888_FFFF4441,
        64'h8888FFFF_11118882,
        64'hFFFF1111_22221114
    };

endpackage

// File: rtl/ecc_chk_gen.sv
// Recomputes the check code of a data word from the parity matrix (R1).
module ecc_chk_gen
    import ecc_loc_pkg::*;
#(
    parameter int DATA_W = LOC_DATA_W,
    parameter int CHK_W  = LOC_CHK_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    for (genvar i = 0; i < CHK_W; i++) begin : g_row
        assign chk_o[i] = ^(data_i & LOC_MASK[i]);
    end

endmodule

// File: rtl/ecc_col_search.sv
// Finds the lowest data line whose column code equals the syndrome (R3).
module ecc_col_search
    import ecc_loc_pkg::*;
#(
    parameter int DATA_W = LOC_DATA_W,
    parameter int CHK_W  = LOC_CHK_W,
    localparam int IW    = $clog2(DATA_W)
) (
    input  logic              en_i,
    input  logic [CHK_W-1:0]  syn_i,
    output logic              hit_o,
    output logic [IW-1:0]     idx_o
);

    logic [CHK_W-1:0] col [DATA_W];

    for (genvar b = 0; b < DATA_W; b++) begin : g_col
        for (genvar i = 0; i < CHK_W; i++) begin : g_bit
            assign col[b][i] = LOC_MASK[i][b];
        end
    end

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            if (en_i && (col[b] == syn_i)) begin
                hit_o = 1'b1;
                idx_o = IW'(b);
            end
        end
    end

endmodule

// File: rtl/ecc_low_bit.sv
// Lowest set bit of a vector plus a more-than-one-bit indication (R4, R5).
module ecc_low_bit #(
    parameter int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          any_o,
    output logic          multi_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (vec_i[k]) idx_o = IW'(k);
        end
        any_o   = |vec_i;
        multi_o = ($countones(vec_i) > 1);
    end

endmodule

// File: rtl/ecc_sbe_locator.sv
module ecc_sbe_locator
    import ecc_loc_pkg::*;
#(
    parameter int CAP_W = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic [LOC_DATA_W-1:0] data_i,
    input  logic [CAP_W-1:0]      cap_code_i,
    input  logic                  sbe_i,
    input  logic                  bus64_i,
    output logic                  valid_o,
    output logic                  data_bad_vld_o,
    output logic [LOC_DIDX_W-1:0] data_bad_idx_o,
    output logic                  chk_bad_vld_o,
    output logic [LOC_CIDX_W-1:0] chk_bad_idx_o,
    output logic                  uncorr_o,
    output logic [LOC_DATA_W-1:0] exp_data_o,
    output logic [CAP_W-1:0]      exp_chk_o,
    output logic [CAP_W-1:0]      syndrome_o
);

    typedef struct packed {
        logic                  valid;
        logic                  dvld;
        logic [LOC_DIDX_W-1:0] didx;
        logic                  cvld;
        logic [LOC_CIDX_W-1:0] cidx;
        logic                  uncorr;
        logic [LOC_DATA_W-1:0] exp_data;
        logic [CAP_W-1:0]      exp_chk;
        logic [CAP_W-1:0]      masked;
    } res_t;

    res_t st_d, st_q;

    logic [CAP_W-1:0]      masked;
    logic [LOC_CHK_W-1:0]  calc;
    logic [LOC_CHK_W-1:0]  syn;
    logic                  run;
    logic                  d_hit;
    logic [LOC_DIDX_W-1:0] d_idx;
    logic                  c_any;
    logic                  c_multi;
    logic [LOC_CIDX_W-1:0] c_idx;

    // R2: mask the captured code by bus width
    assign masked = bus64_i ? CAP_W'(cap_code_i[LOC_CHK_W-1:0]) : cap_code_i;
    // R7: decode gate
    assign run    = sbe_i && bus64_i;

    ecc_chk_gen #(.DATA_W(LOC_DATA_W), .CHK_W(LOC_CHK_W)) u_gen (
        .data_i (data_i),
        .chk_o  (calc)
    );

    assign syn = calc ^ masked[LOC_CHK_W-1:0];

    ecc_col_search #(.DATA_W(LOC_DATA_W), .CHK_W(LOC_CHK_W)) u_search (
        .en_i  (run && (|syn)),
        .syn_i (syn),
        .hit_o (d_hit),
        .idx_o (d_idx)
    );

    ecc_low_bit #(.W(LOC_CHK_W)) u_low (
        .vec_i   ((run && !d_hit) ? syn : '0),
        .any_o   (c_any),
        .multi_o (c_multi),
        .idx_o   (c_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = start_i;
        if (start_i) begin
            st_d.dvld     = d_hit;
            st_d.didx     = d_hit ? d_idx : '0;
            st_d.cvld     = c_any;
            st_d.cidx     = c_any ? c_idx : '0;
            st_d.uncorr   = c_any && c_multi;
            st_d.masked   = masked;
            st_d.exp_data = data_i ^ (d_hit ? (LOC_DATA_W'(1) << d_idx) : '0);
            st_d.exp_chk  = masked ^ (c_any ? (CAP_W'(1) << c_idx) : '0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign valid_o        = st_q.valid;
    assign data_bad_vld_o = st_q.dvld;
    assign data_bad_idx_o = st_q.didx;
    assign chk_bad_vld_o  = st_q.cvld;
    assign chk_bad_idx_o  = st_q.cidx;
    assign uncorr_o       = st_q.uncorr;
    assign exp_data_o     = st_q.exp_data;
    assign exp_chk_o      = st_q.exp_chk;
    assign syndrome_o     = st_q.masked;

    assert_valid_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> valid_o);
    assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> !valid_o);
    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> $stable(exp_data_o) && $stable(syndrome_o));
    assert_one_location_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(data_bad_vld_o && chk_bad_vld_o));
    assert_uncorr_on_chk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uncorr_o |-> chk_bad_vld_o);
    assert_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !(sbe_i && bus64_i)) |=> !data_bad_vld_o && !chk_bad_vld_o && !uncorr_o);
    assert_single_flip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> ($countones(exp_data_o ^ $past(data_i)) <= 1));
    assert_mask64_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && bus64_i) |=> (syndrome_o[CAP_W-1:LOC_CHK_W] == '0));

endmodule

// File: tb/ecc_sbe_locator_tb_top.sv
`timescale 1ns/1ps
module ecc_sbe_locator_tb_top;

    localparam int CAP_W = 16;
    localparam logic [63:0] M [8] = '{
        64'hF00FE11E_C33C0FF7, 64'h00FF00FF_00FFF0FF,
        64'h0F0F0F0F_0F0FFF00, 64'h11113333_7777000F,
        64'h22224444_8888222F, 64'h44448888_FFFF4441,
        64'h8888FFFF_11118882, 64'hFFFF1111_22221114
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [63:0] data = '0;
    logic [CAP_W-1:0] cap = '0;
    logic sbe = 1'b0;
    logic bus64 = 1'b0;
    logic valid, dvld, cvld, uncorr;
    logic [5:0] didx;
    logic [2:0] cidx;
    logic [63:0] exp_data;
    logic [CAP_W-1:0] exp_chk, syn_o;

    int n_tests = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ecc_sbe_locator #(.CAP_W(CAP_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data),
        .cap_code_i(cap), .sbe_i(sbe), .bus64_i(bus64), .valid_o(valid),
        .data_bad_vld_o(dvld), .data_bad_idx_o(didx), .chk_bad_vld_o(cvld),
        .chk_bad_idx_o(cidx), .uncorr_o(uncorr), .exp_data_o(exp_data),
        .exp_chk_o(exp_chk), .syndrome_o(syn_o)
    );

    function automatic logic [7:0] ref_ecc(logic [63:0] d);
        logic [7:0] c;
        for (int i = 0; i < 8; i++) c[i] = ^(d & M[i]);
        return c;
    endfunction

    function automatic logic [7:0] ref_col(int b);
        logic [7:0] c;
        for (int i = 0; i < 8; i++) c[i] = M[i][b];
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic txn(input logic [63:0] d, input logic [CAP_W-1:0] c, input logic s, input logic b64);
        logic [CAP_W-1:0] m;
        logic [7:0] sy;
        logic e_dv, e_cv, e_un;
        int e_di, e_ci;
        logic [63:0] e_ed;
        logic [CAP_W-1:0] e_ec;
        m = b64 ? CAP_W'(c[7:0]) : c;
        sy = ref_ecc(d) ^ m[7:0];
        e_dv = 0; e_cv = 0; e_un = 0; e_di = 0; e_ci = 0;
        if (s && b64 && sy != 0) begin
            for (int b = 0; b < 64; b++) begin
                if (!e_dv && ref_col(b) == sy) begin e_dv = 1; e_di = b; end
            end
            if (!e_dv) begin
                for (int k = 7; k >= 0; k--) if (sy[k]) e_ci = k;
                e_cv = 1;
                e_un = ($countones(sy) > 1);
            end
        end
        e_ed = d ^ (e_dv ? (64'd1 << e_di) : 64'd0);
        e_ec = m ^ (e_cv ? (CAP_W'(1) << e_ci) : '0);
        @(negedge clk);
        data = d; cap = c; sbe = s; bus64 = b64; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        data = ~d; cap = ~c;
        chk(valid === 1'b1, "R9 valid after start", 64'(valid), 64'd1);
        chk(syn_o === m, "R2 masked code", 64'(syn_o), 64'(m));
        chk(dvld === e_dv && (!e_dv || didx == 6'(e_di)), "R3 data line R1",
            {dvld, 57'd0, didx}, {e_dv, 57'd0, 6'(e_di)});
        chk(cvld === e_cv && (!e_cv || cidx == 3'(e_ci)), "R4 check line",
            {cvld, 60'd0, cidx}, {e_cv, 60'd0, 3'(e_ci)});
        chk(uncorr === e_un, "R5 uncorrectable", 64'(uncorr), 64'(e_un));
        chk(exp_data === e_ed, "R8 R6 R7 expected data", exp_data, e_ed);
        chk(exp_chk === e_ec, "R8 R6 R7 expected code", 64'(exp_chk), 64'(e_ec));
        @(negedge clk);
        chk(valid === 1'b0, "R9 single pulse", 64'(valid), 64'd0);
        chk(exp_data === e_ed, "R9 hold", exp_data, e_ed);
    endtask

    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid === 0 && dvld === 0 && cvld === 0 && uncorr === 0 &&
            exp_data === 0 && exp_chk === 0 && syn_o === 0, "R10 reset state",
            {valid, dvld, cvld, uncorr, exp_data[59:0]}, 64'd0);

        d = 64'h0123_4567_89AB_CDEF;
        txn(d, CAP_W'(ref_ecc(d)), 1, 1);                         // R6 clean word
        txn(d ^ 64'd1, CAP_W'(ref_ecc(d)), 1, 1);                 // R3 line 0
        txn(d ^ (64'd1 << 63), CAP_W'(ref_ecc(d)), 1, 1);         // R3 line 63
        txn(d, CAP_W'(ref_ecc(d) ^ 8'h80), 1, 1);                 // R4 check line 7
        txn(d ^ 64'h11, CAP_W'(ref_ecc(d)), 1, 1);                // R5 double error
        txn(d ^ 64'd4, CAP_W'(ref_ecc(d)), 0, 1);                 // R7 no sbe flag
        txn(d ^ 64'd4, {8'hA5, ref_ecc(d)}, 1, 0);                // R7 R2 32-bit bus
        txn(d, {8'h3C, ref_ecc(d)}, 1, 1);                        // R2 upper byte dropped

        for (int t = 0; t < 400; t++) begin
            logic [63:0] w;
            logic [7:0] c;
            int kind;
            w = {$urandom, $urandom};
            c = ref_ecc(w);
            kind = int'($urandom % 4);
            if (kind == 1) w[$urandom % 64] ^= 1'b1;
            else if (kind == 2) c[$urandom % 8] ^= 1'b1;
            else if (kind == 3) begin
                w[$urandom % 64] ^= 1'b1;
                c[$urandom % 8] ^= 1'b1;
            end
            txn(w, {8'($urandom), c}, ($urandom % 8) != 0, ($urandom % 8) != 0);
        end
        finish_run();
    end

endmodule